// File: doc/BRIEF.md
# Packed Float Compare Mask Unit

This block compares two 128-bit operands, each holding four IEEE-754 single-precision lanes. Lane 0 sits in bits 31:0 and lane 3 in bits 127:96. A 3-bit predicate code selects the comparison. Each compared lane returns a full 32-bit mask: all ones when the predicate holds, all zeros when it does not. The comparison treats NaN inputs exactly, and it treats the two signed zeros as equal.

A mode input chooses between two ways of working:

- **Packed:** all four lanes are compared independently.
- **Scalar:** only lane 0 is compared, and lanes 1 to 3 of operand A pass through to the result unchanged.

A 4-bit sign mask is taken from the top bit of each result lane. Operands are captured on `in_valid`. The result, sign mask and `out_valid` are registered and appear one clock later. Between accepted inputs the outputs hold their last value.

Top module: `fcmp_mask_unit`

## Requirements
- R1: Every compared result lane equals 0xFFFFFFFF when the predicate holds and 0x00000000 when it does not.
- R2: The `pred` encoding for the base predicates is: 0 = A equal B, 1 = A less than B, 2 = A less than or equal B.
- R3: `pred` codes 4, 5 and 6 give the logical negations of codes 0, 1 and 2: not-equal, not-less-than and not-less-or-equal.
- R4: If either operand of a lane is NaN, codes 0, 1, 2 and 7 (ordered) give false, and codes 3 (unordered), 4, 5 and 6 give true. When neither operand is NaN, code 3 gives false and code 7 gives true. A NaN is an exponent of all ones with a nonzero fraction; infinity equals infinity.
- R5: Positive zero (0x00000000) and negative zero (0x80000000) compare as equal, and neither is less than the other.
- R6: Ordering follows numeric value: any negative value is below any positive value, and among negative values a larger magnitude is the smaller number.
- R7: With `scalar`=0, all four lanes are compared independently with the same predicate.
- R8: With `scalar`=1, only lane 0 is compared. Result bits 127:32 equal operand A bits 127:32.
- R9: `out_sign` bit i equals bit 31 of result lane i, with lane 0 in bit 0.
- R10: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Each result appears together with its `out_valid`.
- R11: While `rst_n` is low, `out_valid`, `out_res` and `out_sign` are zero.
- R12: Greater-than is obtained by applying code 1 with the operands swapped. Greater-or-equal is obtained the same way from code 2.
- R13: In a cycle with `in_valid` low, `out_res` and `out_sign` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and predicate are valid this cycle |
| op_a | input | 128 | Operand A, four float lanes, lane 0 in the low bits |
| op_b | input | 128 | Operand B, four float lanes |
| pred | input | 3 | Predicate code |
| scalar | input | 1 | 1 = compare lane 0 only and pass A's upper lanes through |
| out_valid | output | 1 | Result valid |
| out_res | output | 128 | Result lanes |
| out_sign | output | 4 | Top bit of each result lane |

## Verification
The assertions assume that `op_a`, `op_b`, `pred` and `scalar` are stable and meaningful only in cycles where `in_valid` is high. They never reason about values presented while `in_valid` is low. The stimulus changes every input half a period away from the sampling edge and lowers `in_valid` between scenarios. The lane-mask property assumes packed mode; scalar transfers are checked for pass-through instead. The stimulus therefore places deliberately non-mask patterns in A's upper lanes only during scalar transfers.

// File: rtl/fcmp_mask_unit.sv
module fcmp_mask_unit #(
  parameter int LANES = 4,
  parameter int LW    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [LANES*LW-1:0] op_a,
  input  logic [LANES*LW-1:0] op_b,
  input  logic [2:0]         pred,
  input  logic               scalar,
  output logic               out_valid,
  output logic [LANES*LW-1:0] out_res,
  output logic [LANES-1:0]   out_sign
);
  localparam int EW = 8;
  localparam int MW = LW - EW - 1;

  logic [LANES*LW-1:0] nxt_res;
  logic [LANES-1:0]    nxt_sign;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LW-1:0] a, b;
    logic          sa, sb, nan_a, nan_b, un, zz, eq, lt;
    logic [LW-2:0] ma, mb;
    logic [3:0]    base;
    logic          hit;
    assign a     = op_a[i*LW +: LW];
    assign b     = op_b[i*LW +: LW];
    assign sa    = a[LW-1];
    assign sb    = b[LW-1];
    assign ma    = a[LW-2:0];
    assign mb    = b[LW-2:0];
    assign nan_a = (&a[LW-2:MW]) && (|a[MW-1:0]);
    assign nan_b = (&b[LW-2:MW]) && (|b[MW-1:0]);
    assign un    = nan_a | nan_b;
    assign zz    = (ma == '0) && (mb == '0);
    assign eq    = zz || (a == b);
    always_comb begin
      if (zz)            lt = 1'b0;
      else if (sa != sb) lt = sa;
      else if (sa)       lt = ma > mb;
      else               lt = ma < mb;
    end
    assign base = {un, (lt | eq) & ~un, lt & ~un, eq & ~un};
    assign hit  = base[pred[1:0]] ^ pred[2];
    if (i == 0) begin : g_cmp
      assign nxt_res[i*LW +: LW] = {LW{hit}};
      assign nxt_sign[i]         = hit;
    end else begin : g_mix
      assign nxt_res[i*LW +: LW] = scalar ? a : {LW{hit}};
      assign nxt_sign[i]         = scalar ? sa : hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_sign  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_res  <= nxt_res;
        out_sign <= nxt_sign;
      end
    end
  end
endmodule

// File: rtl/fcmp_mask_unit_chk.sv
module fcmp_mask_unit_chk #(
  parameter int LANES = 4,
  parameter int LW    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [LANES*LW-1:0] op_a,
  input logic [2:0]          pred,
  input logic                scalar,
  input logic                out_valid,
  input logic [LANES*LW-1:0] out_res,
  input logic [LANES-1:0]    out_sign
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R10
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R10
  AST_HOLD_RES: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_res) && $stable(out_sign)); // R13
  AST_LANE0_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_res[LW-1:0] == '0 || out_res[LW-1:0] == '1)); // R1
  AST_SCALAR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && scalar |=> out_res[LANES*LW-1:LW] == $past(op_a[LANES*LW-1:LW])); // R8
  AST_ORD_NOT_UN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && pred == 3'd7 && (&op_a[LW-2:LW-9]) && (|op_a[LW-10:0]) |=> out_res[LW-1:0] == '0); // R4
  AST_SIGN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sign[0] == out_res[LW-1]); // R9
endmodule

bind fcmp_mask_unit fcmp_mask_unit_chk #(.LANES(LANES), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .pred(pred),
  .scalar(scalar), .out_valid(out_valid), .out_res(out_res), .out_sign(out_sign));

// File: tb/sim_fcmp_mask_unit.sv
module sim_fcmp_mask_unit;
  localparam logic [31:0] P1 = 32'h3F800000, P2 = 32'h40000000;
  localparam logic [31:0] N1 = 32'hBF800000, N2 = 32'hC0000000;
  localparam logic [31:0] PZ = 32'h00000000, NZ = 32'h80000000;
  localparam logic [31:0] QN = 32'h7FC00000, PI = 32'h7F800000;

  logic clk = 0, rst_n = 0, in_valid = 0, scalar = 0;
  logic [127:0] op_a = '0, op_b = '0;
  logic [2:0] pred = '0;
  logic out_valid;
  logic [127:0] out_res;
  logic [3:0] out_sign;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  fcmp_mask_unit u0 (.clk, .rst_n, .in_valid, .op_a, .op_b, .pred, .scalar,
                     .out_valid, .out_res, .out_sign);

  function automatic logic [127:0] pk(logic [31:0] l0, l1, l2, l3);
    return {l3, l2, l1, l0};
  endfunction
  function automatic logic [127:0] mk(logic [3:0] m);
    return pk({32{m[0]}}, {32{m[1]}}, {32{m[2]}}, {32{m[3]}});
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic xfer(logic [127:0] a, logic [127:0] b, logic [2:0] p, logic s);
    @(negedge clk);
    op_a = a; op_b = b; pred = p; scalar = s; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic cmp_packed(string req, logic [127:0] a, logic [127:0] b,
                            logic [2:0] p, logic [3:0] m);
    xfer(a, b, p, 0);
    chk(req, {127'd0, out_valid}, 128'd1);
    chk(req, out_res, mk(m));
    chk(req, {124'd0, out_sign}, {124'd0, m});
  endtask

  task automatic t_reset;
    chk("R11", {out_sign, out_res, out_valid}, '0);
  endtask

  task automatic t_base;
    logic [127:0] a = pk(P1, P2, N2, N1), b = pk(P2, P2, N1, N2);
    cmp_packed("R2_eq R1 R7", a, b, 3'd0, 4'b0010);
    cmp_packed("R2_lt R6", a, b, 3'd1, 4'b0101);
    cmp_packed("R2_le R6", a, b, 3'd2, 4'b0111);
  endtask

  task automatic t_neg;
    logic [127:0] a = pk(P1, P2, N2, N1), b = pk(P2, P2, N1, N2);
    cmp_packed("R3_neq", a, b, 3'd4, 4'b1101);
    cmp_packed("R3_nlt", a, b, 3'd5, 4'b1010);
    cmp_packed("R3_nle", a, b, 3'd6, 4'b1000);
  endtask

  task automatic t_nan;
    logic [127:0] a = pk(QN, P1, PI, PZ), b = pk(P1, QN, PI, NZ);
    cmp_packed("R4_unord", a, b, 3'd3, 4'b0011);
    cmp_packed("R4_ord", a, b, 3'd7, 4'b1100);
    cmp_packed("R4_eq", a, b, 3'd0, 4'b1100);
    cmp_packed("R4_neq", a, b, 3'd4, 4'b0011);
    cmp_packed("R4_lt", a, b, 3'd1, 4'b0000);
    cmp_packed("R4_nlt", a, b, 3'd5, 4'b1111);
  endtask

  task automatic t_zero;
    logic [127:0] a = pk(PZ, NZ, NZ, PZ), b = pk(NZ, PZ, NZ, P1);
    cmp_packed("R5_le", a, b, 3'd2, 4'b1111);
    cmp_packed("R5_lt", a, b, 3'd1, 4'b1000);
  endtask

  task automatic t_gt;
    logic [127:0] a = pk(P2, P1, N1, N2), b = pk(P1, P1, N2, N1);
    cmp_packed("R12_gt", b, a, 3'd1, 4'b0101);
    cmp_packed("R12_ge", b, a, 3'd2, 4'b0111);
  endtask

  task automatic t_scalar;
    logic [127:0] a = pk(P1, 32'h11111111, 32'h22222222, 32'h83333333);
    logic [127:0] b = pk(P2, P1, P1, P1);
    xfer(a, b, 3'd1, 1);
    chk("R8_lane0", out_res[31:0], {96'd0, 32'hFFFFFFFF});
    chk("R8_upper", out_res[127:32], a[127:32]);
    chk("R9_scalar", {124'd0, out_sign}, {124'd0, 4'b1001});
    xfer(pk(P2, 32'h44444444, PZ, PZ), b, 3'd1, 1);
    chk("R8_false", out_res, pk(PZ, 32'h44444444, PZ, PZ));
  endtask

  task automatic t_hold;
    logic [127:0] keep;
    cmp_packed("R10", pk(P1, P1, P1, P1), pk(P2, P2, P2, P2), 3'd1, 4'b1111);
    keep = out_res;
    op_a = '0; op_b = '0;
    @(negedge clk);
    chk("R10_idle", {127'd0, out_valid}, 128'd0);
    chk("R13", out_res, keep);
  endtask

  task automatic t_rst_mid;
    @(negedge clk);
    op_a = pk(P1, P1, P1, P1); op_b = pk(P2, P2, P2, P2); pred = 3'd1;
    in_valid = 1; rst_n = 0;
    @(negedge clk);
    in_valid = 0;
    chk("R11_mid", {out_sign, out_res, out_valid}, '0);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_base();
    t_neg();
    t_nan();
    t_zero();
    t_gt();
    t_scalar();
    t_hold();
    t_rst_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule